// File: doc/BRIEF.md
# Reservation Monitor for Load-Reserved / Store-Conditional

This block sits on the memory side of a shared memory and keeps the reservations that requesting contexts build up with load-reserved reads. It has a read request port and a write request port, and both may be active in the same cycle. A read that carries the reserve flag records, for its context, the address granule it touched. A context owns at most one reservation, so a repeat reserve from the same context moves it to the new granule.

Every write is compared with all reservations. It does not matter whether the write is a plain store or a store-conditional. A store-conditional commits only when a live reservation matches both its granule and its context. A plain store always commits. After the write, all reservations on the written granule are dropped, whatever context owns them and whether the write committed. The commit result `wr_ok` is combinational and valid in the same cycle as the write request. It is 1 for commit and 0 for failure, and it is returned to the requester as the store-conditional status.

When a reserve and a write occur in the same cycle, the write is applied first. A reservation created in that cycle therefore survives a same-cycle write to its own granule.

Top module: `resv_monitor`

## Requirements
- R1: Addresses are compared by granule only. The low `GRAN_BITS` bits (default 3, an 8-byte granule) are ignored, so a reservation at 0x101 covers 0x100 through 0x107 and not 0x108.
- R2: Each context holds at most one reservation. A repeat reserve from the same context moves it to the new granule, and the old granule no longer counts for that context.
- R3: A reserve from a context with no reservation creates one. With the default 8 entries, all 8 contexts can hold reservations at the same time.
- R4: A plain store (`wr_valid`=1, `wr_cond`=0) always gives `wr_ok`=1 in the same cycle.
- R5: A store-conditional gives `wr_ok`=1 only if a live reservation matches both its granule and its `wr_ctx`. Otherwise it gives 0.
- R6: Any write removes every reservation on its granule: those of other contexts, and also when the write is a failed store-conditional.
- R7: Several contexts may hold reservations on the same granule at the same time, and each of them is able to commit.
- R8: A read without the reserve flag does not create, move or remove any reservation.
- R9: For a reserve and a write in the same cycle, the write is applied first. The new reservation survives even when the write targets the same granule, and an older reservation on the written granule is still removed.
- R10: `wr_ok` is 0 in every cycle where `wr_valid` is 0.
- R11: Reset removes every reservation.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rd_valid | input | 1 | Read request present |
| rd_reserve | input | 1 | Read is a load-reserved |
| rd_ctx | input | CTXW | Context of the read |
| rd_addr | input | AW | Read byte address |
| wr_valid | input | 1 | Write request present |
| wr_cond | input | 1 | Write is a store-conditional |
| wr_ctx | input | CTXW | Context of the write |
| wr_addr | input | AW | Write byte address |
| wr_ok | output | 1 | Write may commit (store-conditional status) |

## Verification
Store-conditionals are issued against reservations that differ from them only in the address inside the granule, only across the granule edge, or only in context. Each of these three cases shows whether the match uses both fields and the correct address bits. Sequences with two contexts on one granule, followed by plain or conditional writes from a third context or from one of the owners, separate "clear every holder" from "clear only the writer". Further patterns check that an owner keeps its reservation when another owner is not overwritten. Reserve and write are also issued in the same cycle, on the same granule and on different granules, which shows the write-first order. Reserve repeats, plain reads, all eight contexts filling the table, and a mid-run reset cover moving, ignoring, capacity and clearing.

// File: rtl/resv_pkg.sv
package resv_pkg;

    localparam int MAX_ENTRIES = 32;

    // index of the lowest set bit, 0 when none is set
    function automatic logic [4:0] low_idx(input logic [MAX_ENTRIES-1:0] v);
        logic [4:0] r;
        r = '0;
        for (int i = MAX_ENTRIES - 1; i >= 0; i--) begin
            if (v[i]) r = 5'(i);
        end
        return r;
    endfunction

endpackage

// File: rtl/resv_match.sv
module resv_match #(
    parameter int N = 8,
    parameter int W = 8
) (
    input  logic [N-1:0][W-1:0] field,
    input  logic [W-1:0]        key,
    output logic [N-1:0]        hit
);
    for (genvar e = 0; e < N; e++) begin : g_cmp
        assign hit[e] = (field[e] == key);
    end
endmodule

// File: rtl/resv_table.sv
module resv_table #(
    parameter int ENTRIES = 8,
    parameter int AW      = 32,
    parameter int CTXW    = 3,
    parameter int IDXW    = 3
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic [ENTRIES-1:0]             clr_vec,
    input  logic                           set_en,
    input  logic [IDXW-1:0]                set_idx,
    input  logic [AW-1:0]                  set_tag,
    input  logic [CTXW-1:0]                set_ctx,
    output logic [ENTRIES-1:0]             vld_q,
    output logic [ENTRIES-1:0][AW-1:0]     tag_q,
    output logic [ENTRIES-1:0][CTXW-1:0]   ctx_q
);
    typedef struct packed {
        logic [ENTRIES-1:0]           vld;
        logic [ENTRIES-1:0][AW-1:0]   tag;
        logic [ENTRIES-1:0][CTXW-1:0] ctx;
    } tbl_t;

    tbl_t tbl_d, tbl_q;

    always_comb begin
        tbl_d     = tbl_q;
        // write side first: drop every entry on the written granule
        tbl_d.vld = tbl_q.vld & ~clr_vec;
        // then the reserve lands, so it is never undone by the same write
        if (set_en) begin
            tbl_d.vld[set_idx] = 1'b1;
            tbl_d.tag[set_idx] = set_tag;
            tbl_d.ctx[set_idx] = set_ctx;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tbl_q <= '0;
        end else begin
            tbl_q <= tbl_d;
        end
    end

    assign vld_q = tbl_q.vld;
    assign tag_q = tbl_q.tag;
    assign ctx_q = tbl_q.ctx;
endmodule

// File: rtl/resv_monitor.sv
module resv_monitor #(
    parameter int AW        = 32,
    parameter int CTXW      = 3,
    parameter int ENTRIES   = 8,
    parameter int GRAN_BITS = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            rd_valid,
    input  logic            rd_reserve,
    input  logic [CTXW-1:0] rd_ctx,
    input  logic [AW-1:0]   rd_addr,
    input  logic            wr_valid,
    input  logic            wr_cond,
    input  logic [CTXW-1:0] wr_ctx,
    input  logic [AW-1:0]   wr_addr,
    output logic            wr_ok
);
    import resv_pkg::*;

    localparam int IDXW = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
    localparam int NCTX = 1 << CTXW;
    localparam logic [AW-1:0] GRAN_MASK = ~((AW'(1) << GRAN_BITS) - AW'(1));

    logic [AW-1:0]                rd_tag, wr_tag;
    logic [ENTRIES-1:0]           vld_q;
    logic [ENTRIES-1:0][AW-1:0]   tag_q;
    logic [ENTRIES-1:0][CTXW-1:0] ctx_q;
    logic [ENTRIES-1:0]           w_tag_hit, w_ctx_hit, r_ctx_hit;
    logic [ENTRIES-1:0]           clr_vec, vld_after, own_vec, free_vec;
    logic                         lr_req, set_en;
    logic [IDXW-1:0]              set_idx;

    assign rd_tag = rd_addr & GRAN_MASK;
    assign wr_tag = wr_addr & GRAN_MASK;

    resv_match #(.N(ENTRIES), .W(AW)) u_wtag (
        .field(tag_q), .key(wr_tag), .hit(w_tag_hit));
    resv_match #(.N(ENTRIES), .W(CTXW)) u_wctx (
        .field(ctx_q), .key(wr_ctx), .hit(w_ctx_hit));
    resv_match #(.N(ENTRIES), .W(CTXW)) u_rctx (
        .field(ctx_q), .key(rd_ctx), .hit(r_ctx_hit));

    // write path: commit decision and granule clear
    assign clr_vec = wr_valid ? (vld_q & w_tag_hit) : '0;
    assign wr_ok   = wr_valid & (~wr_cond | (|(vld_q & w_tag_hit & w_ctx_hit)));

    // reserve path sees the table as it is after the write
    assign vld_after = vld_q & ~clr_vec;
    assign own_vec   = vld_after & r_ctx_hit;
    assign free_vec  = ~vld_after;
    assign lr_req    = rd_valid & rd_reserve;
    assign set_en    = lr_req & ((|own_vec) | (|free_vec));
    assign set_idx   = (|own_vec) ? IDXW'(low_idx(MAX_ENTRIES'(own_vec)))
                                  : IDXW'(low_idx(MAX_ENTRIES'(free_vec)));

    resv_table #(.ENTRIES(ENTRIES), .AW(AW), .CTXW(CTXW), .IDXW(IDXW)) u_tbl (
        .clk(clk), .rst_n(rst_n), .clr_vec(clr_vec), .set_en(set_en),
        .set_idx(set_idx), .set_tag(rd_tag), .set_ctx(rd_ctx),
        .vld_q(vld_q), .tag_q(tag_q), .ctx_q(ctx_q));

    // ---------------- assertions ----------------
    p_plain_ok_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && !wr_cond) |-> wr_ok);

    p_idle_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_valid |-> !wr_ok);

    logic lr_same;
    assign lr_same = lr_req && (rd_tag == wr_tag);

    for (genvar e = 0; e < ENTRIES; e++) begin : g_clr_chk
        p_granule_cleared_r6: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_valid && !lr_same) |=> !(vld_q[e] && tag_q[e] == $past(wr_tag)));
    end

    logic [AW-1:0]   lr_tag_q;
    logic [CTXW-1:0] lr_ctx_q;
    logic            lr_found;
    always_ff @(posedge clk) begin
        lr_tag_q <= rd_tag;
        lr_ctx_q <= rd_ctx;
    end
    always_comb begin
        lr_found = 1'b0;
        for (int e = 0; e < ENTRIES; e++) begin
            if (vld_q[e] && tag_q[e] == lr_tag_q && ctx_q[e] == lr_ctx_q) lr_found = 1'b1;
        end
    end
    p_reserve_held_r3: assert property (@(posedge clk) disable iff (!rst_n)
        set_en |=> lr_found);

    for (genvar c = 0; c < NCTX; c++) begin : g_ctx_chk
        logic [ENTRIES-1:0] owns;
        always_comb begin
            for (int e = 0; e < ENTRIES; e++) begin
                owns[e] = vld_q[e] && (ctx_q[e] == CTXW'(c));
            end
        end
        p_single_resv_r2: assert property (@(posedge clk) disable iff (!rst_n)
            $countones(owns) <= 1);
    end
endmodule

// File: tb/sim_resv_monitor.sv
`timescale 1ns/1ps
module sim_resv_monitor;
    localparam int AW = 32;
    localparam int CW = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          rd_valid = 1'b0, rd_reserve = 1'b0;
    logic [CW-1:0] rd_ctx = '0;
    logic [AW-1:0] rd_addr = '0;
    logic          wr_valid = 1'b0, wr_cond = 1'b0;
    logic [CW-1:0] wr_ctx = '0;
    logic [AW-1:0] wr_addr = '0;
    logic          wr_ok;

    int n_tests = 0;
    int n_fail  = 0;
    bit exp_q[$];
    string tag_q[$];

    always #4 clk = ~clk;

    resv_monitor u0 (
        .clk(clk), .rst_n(rst_n),
        .rd_valid(rd_valid), .rd_reserve(rd_reserve), .rd_ctx(rd_ctx), .rd_addr(rd_addr),
        .wr_valid(wr_valid), .wr_cond(wr_cond), .wr_ctx(wr_ctx), .wr_addr(wr_addr),
        .wr_ok(wr_ok));

    // one cycle of stimulus on both ports
    task automatic cyc(input bit rv, input bit rr, input int rc, input int ra,
                       input bit wv, input bit wc, input int wcx, input int wa,
                       input bit exp, input string req);
        @(posedge clk); #1;
        rd_valid = rv; rd_reserve = rr; rd_ctx = CW'(rc); rd_addr = AW'(ra);
        wr_valid = wv; wr_cond = wc; wr_ctx = CW'(wcx); wr_addr = AW'(wa);
        if (wv) begin
            exp_q.push_back(exp);
            tag_q.push_back(req);
        end
    endtask

    task automatic lr(input int c, input int a);
        cyc(1, 1, c, a, 0, 0, 0, 0, 0, "");
    endtask
    task automatic rd(input int c, input int a);
        cyc(1, 0, c, a, 0, 0, 0, 0, 0, "");
    endtask
    task automatic st(input int c, input int a, input bit e, input string req);
        cyc(0, 0, 0, 0, 1, 0, c, a, e, req);
    endtask
    task automatic sc(input int c, input int a, input bit e, input string req);
        cyc(0, 0, 0, 0, 1, 1, c, a, e, req);
    endtask
    task automatic idle();
        cyc(0, 0, 0, 0, 0, 0, 0, 0, 0, "");
    endtask

    // monitor: compares each write result against the scoreboard
    always @(negedge clk) begin
        if (rst_n && wr_valid) begin
            n_tests++;
            if (exp_q.size() == 0) begin
                n_fail++;
                $display("FAIL unexpected write result: wr_ok=%0b expected none", wr_ok);
            end else begin
                automatic bit e = exp_q.pop_front();
                automatic string t = tag_q.pop_front();
                if (wr_ok !== e) begin
                    n_fail++;
                    $display("FAIL %s: wr_ok=%0b expected %0b", t, wr_ok, e);
                end
            end
        end
    end

    task automatic finish_run();
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    endtask

    initial begin
        #(8 * 200000);
        n_fail++;
        $display("FAIL watchdog: run did not end, expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        // R10 / reset state: no write, no commit
        @(negedge clk);
        n_tests++;
        if (wr_ok !== 1'b0) begin
            n_fail++;
            $display("FAIL R10 reset idle: wr_ok=%0b expected 0", wr_ok);
        end

        st(0, 'h40, 1, "R4 plain store commits");
        sc(0, 'h48, 0, "R5 sc with no reservation");

        lr(1, 'h101); sc(1, 'h107, 1, "R1 same granule");
        lr(1, 'h101); sc(1, 'h108, 0, "R1 next granule");
        st(0, 'h100, 1, "R4 plain store");

        lr(2, 'h200); lr(2, 'h210);
        sc(2, 'h200, 0, "R2 old granule dropped");
        sc(2, 'h210, 1, "R2 moved reservation");

        lr(3, 'h300);
        sc(4, 'h300, 0, "R5 context mismatch");
        sc(3, 'h300, 0, "R6 failed sc cleared owner");

        lr(1, 'h400); lr(2, 'h400);
        st(5, 'h400, 1, "R4 plain store");
        sc(1, 'h400, 0, "R6 store clears ctx1");
        sc(2, 'h400, 0, "R6 store clears ctx2");

        lr(1, 'h500); lr(2, 'h500);
        sc(2, 'h500, 1, "R7 second holder commits");
        sc(1, 'h500, 0, "R6 success clears other holder");
        lr(1, 'h580); lr(2, 'h580);
        sc(1, 'h580, 1, "R7 first holder commits");

        for (int c = 0; c < 8; c++) lr(c, 'h600 + c * 'h10);
        for (int c = 0; c < 8; c++) sc(c, 'h600 + c * 'h10, 1, "R3 all contexts reserved");

        lr(1, 'h700); rd(2, 'h700);
        sc(1, 'h700, 1, "R8 plain read kept reservation");
        sc(2, 'h700, 0, "R8 plain read made none");

        cyc(1, 1, 1, 'h800, 1, 0, 3, 'h800, 1, "R9 same-cycle store commits");
        sc(1, 'h800, 1, "R9 new reservation survives");
        lr(2, 'h900);
        cyc(1, 1, 4, 'h980, 1, 0, 5, 'h900, 1, "R9 same-cycle store commits");
        sc(2, 'h900, 0, "R9 older reservation removed");
        sc(4, 'h980, 1, "R9 other granule reserved");
        lr(6, 'hA00);
        cyc(1, 1, 6, 'hA80, 1, 0, 0, 'hA00, 1, "R9 same-cycle store commits");
        sc(6, 'hA80, 1, "R9 moved reservation survives");

        lr(3, 'hB00);
        idle();
        @(posedge clk); #1 rst_n = 1'b0;
        repeat (2) @(posedge clk);
        #1 rst_n = 1'b1;
        sc(3, 'hB00, 0, "R11 reset cleared reservation");
        idle();
        @(negedge clk);
        n_tests++;
        if (wr_ok !== 1'b0) begin
            n_fail++;
            $display("FAIL R10 idle: wr_ok=%0b expected 0", wr_ok);
        end
        repeat (2) @(posedge clk);
        if (exp_q.size() != 0) begin
            n_fail++;
            $display("FAIL scoreboard: %0d left expected 0", exp_q.size());
        end
        finish_run();
    end
endmodule